// File: doc/BRIEF.md
# Fan PWM Controller with Register Interface

This block drives a single fan through one pulse-width-modulated output. The period is fixed at 40 ms. The number of clock cycles in a period is derived from the input clock frequency, which is a parameter. Software controls the block through a small 32-bit word register bus, which holds two registers.

The control word at byte address 0x0 has three fields:
- bit 0 starts and stops the output;
- bit 1 is the fan-mode selector, and only 2-wire mode (value 0) exists;
- bits 23:16 hold an 8-bit duty level.

The word at byte address 0x4 keeps a 16-bit maximum fan speed figure. Software normally programs it to 4000. The block only stores this value for read-back; it never affects the output.

A duty write reaches the output on the next cycle. It does not wait for the period boundary, so the period in which the write lands can mix the old and new levels. Stopping the block clears the output and resets the period phase, so the next start begins a fresh period. The output is high during the active part of each period; there is no inversion.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset, both registers read 0 and `pwm_out` is 0.
- R2: The control register reads back bit 0 (enable) and bits 23:16 (duty) as written. All its other bits read 0.
- R3: Control bit 1 (fan mode) always reads 0, because only 2-wire mode exists. Writing 1 to it changes neither the read-back value nor the output waveform.
- R4: The speed register at 0x4 stores bits 15:0 and reads them back, with bits 31:16 reading 0. Writing it has no effect on the output waveform.
- R5: A write to any address other than 0x0 or 0x4 changes no register. A read of any other address returns 0, and `rdata` is 0 whenever `rd_en` is low.
- R6: The period is PER = CLK_HZ*40/1000 cycles. While enabled, the output is high for the first floor(duty*PER/255) cycles of each period and low for the rest of it.
- R7: While enabled, duty 255 holds the output high on every cycle, and duty 0 holds it low on every cycle.
- R8: Writing enable = 0 drives `pwm_out` to 0 from the next cycle on. A later enable starts a new period at its first cycle, whatever the phase was when the block stopped.
- R9: A duty write takes effect on the next cycle, in the middle of a running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| pwm_out | output | 1 | Fan PWM output |

## Verification
The assertions assume that `wr_en` and `rd_en` are never both high in the same cycle. They also assume that the address is a byte address, of which only 0x0 and 0x4 select a register. The bench drives every bus access as a single one-cycle strobe of one kind, changed at the falling edge. The period length is checked by counting output highs over exactly PER samples that start just after an enabling write. With the default parameters PER is 4000 cycles, so each measured period stays short.

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl #(
  parameter int CLK_HZ = 100000,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              pwm_out
);
  localparam int PER = CLK_HZ * 40 / 1000;
  localparam int CW = $clog2(PER + 1);
  localparam logic [CW-1:0] LAST = CW'(PER - 1);
  localparam logic [CW+7:0] PW = (CW+8)'(PER);
  localparam logic [CW+7:0] FULL = (CW+8)'(255);

  logic          run_q;
  logic [7:0]    duty_q;
  logic [15:0]   spd_q;
  logic [CW-1:0] cnt_q;
  logic [CW+7:0] thr;

  wire sel_ctl = (addr == ADDR_W'(0));
  wire sel_spd = (addr == ADDR_W'(4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      duty_q <= 8'd0;
      spd_q  <= 16'd0;
    end else if (wr_en) begin
      if (sel_ctl) begin
        run_q  <= wdata[0];
        duty_q <= wdata[23:16];
      end
      if (sel_spd) spd_q <= wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_q) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign thr = ({{CW{1'b0}}, duty_q} * PW) / FULL;
  assign pwm_out = run_q && ({8'd0, cnt_q} < thr);

  always_comb begin
    rdata = 32'd0;
    if (rd_en && sel_ctl) rdata = {8'd0, duty_q, 15'd0, run_q};
    else if (rd_en && sel_spd) rdata = {16'd0, spd_q};
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {8'd0, cnt_q} < PW); // R6
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_ctl && !wdata[0]) |=> !pwm_out); // R8
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> cnt_q == '0); // R8
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && duty_q == 8'hFF) |-> pwm_out); // R7
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == 8'h00) |-> !pwm_out); // R7
  AST_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_ctl) |-> !rdata[1]); // R3
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || (!sel_ctl && !sel_spd)) |-> rdata == 32'd0); // R5
endmodule

// File: tb/tb_fan_pwm_ctrl.sv
module tb_fan_pwm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 100000;
  localparam int PER = CLK_HZ * 40 / 1000;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic pwm_out;
  int checks = 0, errors = 0;

  fan_pwm_ctrl #(.CLK_HZ(CLK_HZ), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int thr(int d);
    return d * PER / 255;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [31:0] ctl(int d, bit en);
    return {8'd0, 8'(d), 15'd0, en};
  endfunction

  // Leaves the caller at the negedge right after the write, then counts PER samples.
  task automatic wr_count(logic [3:0] a, logic [31:0] d, output int highs);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    highs = 0;
    for (int i = 0; i < PER; i++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); check("R1 ctl", v, 0);
    rd(4'h4, v); check("R1 spd", v, 0);
    check("R1 pwm", {31'd0, pwm_out}, 0);
  endtask

  task automatic t_period();
    int h;
    wr_count(4'h0, ctl(64, 1), h);  check("R6 duty64", h, thr(64));
    wr(4'h0, ctl(0, 0));
    wr_count(4'h0, ctl(128, 1), h); check("R6 duty128", h, thr(128));
    h = 0;
    for (int i = 0; i < PER; i++) begin if (pwm_out) h++; @(negedge clk); end
    check("R6 second period", h, thr(128));
  endtask

  task automatic t_extremes();
    int h;
    wr_count(4'h0, ctl(255, 1), h); check("R7 duty255", h, PER);
    wr_count(4'h0, ctl(0, 1), h);   check("R7 duty0", h, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    int h;
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v);
    check("R2 R3 ctl readback", v, 32'h00FF_0001);
    wr(4'h0, ctl(0, 0));
    wr_count(4'h0, ctl(64, 1) | 32'h2, h); check("R3 mode bit no effect", h, thr(64));
    wr(4'h4, 32'hFFFF_0FA0); rd(4'h4, v); check("R4 spd readback", v, 32'h0000_0FA0);
    wr(4'h0, ctl(0, 0));
    wr_count(4'h0, ctl(64, 1), h); check("R4 spd no effect", h, thr(64));
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h2, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R5 ctl untouched", v, ctl(64, 1));
    rd(4'h4, v); check("R5 spd untouched", v, 32'h0FA0);
    rd(4'h8, v); check("R5 unmapped read", v, 0);
    @(negedge clk); addr = 4'h4; #1 check("R5 no strobe", rdata, 0);
  endtask

  task automatic t_disable();
    int h;
    wr(4'h0, ctl(128, 1));
    repeat (100) @(negedge clk);
    wr_count(4'h0, ctl(128, 0), h); check("R8 off", h, 0);
    repeat (thr(128) - 10) @(negedge clk);
    wr(4'h0, ctl(128, 0));
    wr_count(4'h0, ctl(128, 1), h); check("R8 fresh period", h, thr(128));
  endtask

  task automatic t_live();
    wr(4'h0, ctl(0, 0));
    wr(4'h0, ctl(64, 1));
    repeat (thr(64) + 200) @(negedge clk);
    check("R9 low before update", {31'd0, pwm_out}, 0);
    wr(4'h0, ctl(255, 1));
    check("R9 high after update", {31'd0, pwm_out}, 1);
    wr(4'h0, ctl(0, 1));
    check("R9 low after update", {31'd0, pwm_out}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_period();
    t_extremes();
    t_readback();
    t_unmapped();
    t_disable();
    t_live();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule